// File: doc/BRIEF.md
# Fixed-Point Format Converter

This block takes a fixed-point number in one format and hands back the same quantity in another. A format has three parts: whether it is two's-complement signed or unsigned, its total width, and how many of its low bits are fractional. Both formats are fixed when the block is built. For example, a signed 16-bit word with 13 fraction bits can be narrowed to a signed 12-bit word with 9 fraction bits.

Each sample arrives with a valid strobe and carries two mode selections. One mode chooses how surplus fraction bits are removed: plain truncation, or round-half-up. The other mode chooses what happens when the result lies outside the output range: keep the low bits, clamp to the nearest limit, or force zero. The two modes are chosen independently. An overflow pulse accompanies any result that did not fit, whichever range mode is in use. The datapath has two register stages. A new sample can be accepted on every cycle.

Top module: `fxc_convert`

## Requirements
- R1: A sample presented with `inValid` high produces exactly one cycle of `outValid` two clock edges later. Back-to-back samples give back-to-back results in the same order. After reset, `outValid`, `ovfFlag` and `outData` are all zero.
- R2: With `roundMode` = 0, surplus fraction bits are discarded, so the result rounds toward negative infinity. For example, -24 in Q16.13 becomes -2 in Q12.9.
- R3: With `roundMode` = 1, half an output LSB is added before the surplus bits are discarded, so exact halves round upward. For example, 24 becomes 2 and -24 becomes -1.
- R4: The carry produced by rounding is included in the range check. For example, 32767 (Q16.13) rounded to Q12.9 gives 2048, which is out of range for that format.
- R5: With `ovfMode` = 0 (and also with the spare code 3), an out-of-range result keeps only its low `OUT_W` bits.
- R6: With `ovfMode` = 1, an out-of-range result is clamped to the largest or the smallest value the output format can hold, depending on which side the value overflowed.
- R7: With `ovfMode` = 2, an out-of-range result is output as zero.
- R8: `ovfFlag` is high, together with `outValid`, for exactly one cycle whenever the result does not fit the output format. This holds in every `ovfMode`. `ovfFlag` is low for every result that fits.
- R9: When the output has more fraction bits than the input, the value is shifted left and zero-filled. `roundMode` has no effect in that case.
- R10: For an unsigned output format, any negative value is out of range on the low side. The range is 0 to 2^OUT_W - 1.
- R11: `outData` keeps its last result while `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies inData and the two modes |
| inData | input | IN_W | Input value in the input format |
| roundMode | input | 1 | 0 selects truncation, 1 selects round-half-up |
| ovfMode | input | 2 | 0 wraps, 1 saturates, 2 forces zero, 3 wraps |
| outValid | output | 1 | Result strobe, two cycles after inValid |
| outData | output | OUT_W | Result in the output format |
| ovfFlag | output | 1 | One-cycle pulse with outValid when the result was out of range |

## Verification
A sample launched on one rising edge is captured by the alignment stage on that edge. Its result, strobe and overflow pulse appear after the following edge, so all three are due two edges after launch. The bench drives inputs on falling edges and samples on the falling edge that follows the second rising edge. It also checks one falling edge earlier, to confirm that the strobe has not yet appeared, and one later, to confirm that the strobe and the overflow pulse have dropped while the data holds. A back-to-back scenario launches two samples on consecutive cycles and expects their results on consecutive falling edges.

// File: rtl/fxc_pkg.sv
package fxc_pkg;

  typedef enum logic [1:0] {
    OVF_WRAP = 2'd0,
    OVF_SAT  = 2'd1,
    OVF_ZERO = 2'd2,
    OVF_SPARE = 2'd3
  } ovf_mode_e;

  typedef struct packed {
    logic      s1Load;
    logic      roundOn;
    logic      s2Load;
    ovf_mode_e s2Mode;
  } fxc_strobe_t;

  function automatic int alignWidth(int inW, int inFrac, int outFrac);
    return inW + 2 + ((outFrac > inFrac) ? (outFrac - inFrac) : 0);
  endfunction

  function automatic int compareWidth(int alnW, int outW);
    return (alnW > outW + 2) ? alnW : outW + 2;
  endfunction

endpackage

// File: rtl/fxc_ctrl.sv
module fxc_ctrl
  import fxc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        roundMode,
  input  logic [1:0]  ovfMode,
  output fxc_strobe_t strobe,
  output logic        outValid
);

  logic      validS1;
  logic      validS2;
  ovf_mode_e modeS1;

  always_ff @(posedge clk) begin
    if (rst) begin
      validS1 <= 1'b0;
      validS2 <= 1'b0;
      modeS1  <= OVF_WRAP;
    end else begin
      validS1 <= inValid;
      validS2 <= validS1;
      if (inValid) begin
        modeS1 <= ovf_mode_e'(ovfMode);
      end
    end
  end

  always_comb begin
    strobe.s1Load  = inValid;
    strobe.roundOn = roundMode;
    strobe.s2Load  = validS1;
    strobe.s2Mode  = modeS1;
  end

  assign outValid = validS2;

endmodule

// File: rtl/fxc_align.sv
module fxc_align #(
  parameter int IN_W      = 16,
  parameter int IN_FRAC   = 13,
  parameter bit IN_SIGNED = 1'b1,
  parameter int OUT_FRAC  = 9,
  parameter int ALN_W     = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    roundOn,
  input  logic [IN_W-1:0]         inData,
  output logic signed [ALN_W-1:0] alignQ
);

  localparam int SHIFT = IN_FRAC - OUT_FRAC;
  localparam int RSH   = (SHIFT > 0) ? SHIFT : 0;
  localparam int LSH   = (SHIFT < 0) ? -SHIFT : 0;
  localparam logic signed [ALN_W-1:0] UNIT = ALN_W'(1);
  localparam logic signed [ALN_W-1:0] HALF = (UNIT <<< RSH) >>> 1;

  logic signed [ALN_W-1:0] wideIn;
  logic signed [ALN_W-1:0] bias;
  logic signed [ALN_W-1:0] biased;
  logic signed [ALN_W-1:0] aligned;

  generate
    if (IN_SIGNED) begin : gSignedIn
      assign wideIn = ALN_W'($signed(inData));
    end else begin : gUnsignedIn
      assign wideIn = ALN_W'($signed({1'b0, inData}));
    end
  endgenerate

  always_comb begin
    bias    = roundOn ? HALF : '0;
    biased  = wideIn + bias;
    aligned = (biased >>> RSH) <<< LSH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alignQ <= '0;
    end else if (load) begin
      alignQ <= aligned;
    end
  end

endmodule

// File: rtl/fxc_clamp.sv
module fxc_clamp
  import fxc_pkg::*;
#(
  parameter int OUT_W      = 12,
  parameter bit OUT_SIGNED = 1'b1,
  parameter int ALN_W      = 18,
  parameter int CMP_W      = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  ovf_mode_e               mode,
  input  logic signed [ALN_W-1:0] alignQ,
  output logic [OUT_W-1:0]        outData,
  output logic                    ovfFlag
);

  localparam logic [CMP_W-1:0] ONE = CMP_W'(1);
  localparam logic signed [CMP_W-1:0] MAXV = OUT_SIGNED ?
    $signed((ONE << (OUT_W - 1)) - ONE) : $signed((ONE << OUT_W) - ONE);
  localparam logic signed [CMP_W-1:0] MINV = OUT_SIGNED ?
    $signed(-(ONE << (OUT_W - 1))) : $signed(CMP_W'(0));

  logic signed [CMP_W-1:0] value;
  logic                    tooHigh;
  logic                    tooLow;
  logic                    outOfRange;
  logic [OUT_W-1:0]        lowBits;
  logic [OUT_W-1:0]        result;

  always_comb begin
    value      = CMP_W'(alignQ);
    tooHigh    = value > MAXV;
    tooLow     = value < MINV;
    outOfRange = tooHigh | tooLow;
    lowBits    = value[OUT_W-1:0];
    case (mode)
      OVF_SAT: begin
        if (tooHigh)     result = MAXV[OUT_W-1:0];
        else if (tooLow) result = MINV[OUT_W-1:0];
        else             result = lowBits;
      end
      OVF_ZERO: result = outOfRange ? '0 : lowBits;
      default:  result = lowBits;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData <= '0;
      ovfFlag <= 1'b0;
    end else if (load) begin
      outData <= result;
      ovfFlag <= outOfRange;
    end else begin
      ovfFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/fxc_datapath.sv
module fxc_datapath
  import fxc_pkg::*;
#(
  parameter int IN_W       = 16,
  parameter int IN_FRAC    = 13,
  parameter bit IN_SIGNED  = 1'b1,
  parameter int OUT_W      = 12,
  parameter int OUT_FRAC   = 9,
  parameter bit OUT_SIGNED = 1'b1,
  parameter int ALN_W      = 18,
  parameter int CMP_W      = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  fxc_strobe_t      strobe,
  input  logic [IN_W-1:0]  inData,
  output logic [OUT_W-1:0] outData,
  output logic             ovfFlag
);

  logic signed [ALN_W-1:0] alignQ;

  fxc_align #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .IN_SIGNED(IN_SIGNED),
    .OUT_FRAC(OUT_FRAC), .ALN_W(ALN_W)
  ) uAlign (
    .clk(clk), .rst(rst), .load(strobe.s1Load), .roundOn(strobe.roundOn),
    .inData(inData), .alignQ(alignQ)
  );

  fxc_clamp #(
    .OUT_W(OUT_W), .OUT_SIGNED(OUT_SIGNED), .ALN_W(ALN_W), .CMP_W(CMP_W)
  ) uClamp (
    .clk(clk), .rst(rst), .load(strobe.s2Load), .mode(strobe.s2Mode),
    .alignQ(alignQ), .outData(outData), .ovfFlag(ovfFlag)
  );

endmodule

// File: rtl/fxc_convert.sv
module fxc_convert
  import fxc_pkg::*;
#(
  parameter int IN_W       = 16,
  parameter int IN_FRAC    = 13,
  parameter bit IN_SIGNED  = 1'b1,
  parameter int OUT_W      = 12,
  parameter int OUT_FRAC   = 9,
  parameter bit OUT_SIGNED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  input  logic             roundMode,
  input  logic [1:0]       ovfMode,
  output logic             outValid,
  output logic [OUT_W-1:0] outData,
  output logic             ovfFlag
);

  localparam int ALN_W = alignWidth(IN_W, IN_FRAC, OUT_FRAC);
  localparam int CMP_W = compareWidth(ALN_W, OUT_W);

  fxc_strobe_t strobe;

  fxc_ctrl uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .roundMode(roundMode),
    .ovfMode(ovfMode), .strobe(strobe), .outValid(outValid)
  );

  fxc_datapath #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .IN_SIGNED(IN_SIGNED),
    .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC), .OUT_SIGNED(OUT_SIGNED),
    .ALN_W(ALN_W), .CMP_W(CMP_W)
  ) uPath (
    .clk(clk), .rst(rst), .strobe(strobe), .inData(inData),
    .outData(outData), .ovfFlag(ovfFlag)
  );

endmodule

// File: rtl/fxc_convert_chk.sv
module fxc_convert_chk
  import fxc_pkg::*;
#(
  parameter int OUT_W      = 12,
  parameter bit OUT_SIGNED = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             outValid,
  input logic [OUT_W-1:0] outData,
  input logic             ovfFlag,
  input logic [1:0]       stageMode
);

  localparam logic [OUT_W-1:0] TOP = OUT_SIGNED ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};
  localparam logic [OUT_W-1:0] BOT = OUT_SIGNED ? {1'b1, {(OUT_W-1){1'b0}}} : {OUT_W{1'b0}};

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##2 outValid); // R1
  AST_OVF_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    ovfFlag |-> outValid); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outData)); // R11
  AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (outValid && ovfFlag && $past(stageMode) == 2'(OVF_SAT)) |-> (outData == TOP || outData == BOT)); // R6
  AST_ZERO_ON_OVF: assert property (@(posedge clk) disable iff (rst)
    (outValid && ovfFlag && $past(stageMode) == 2'(OVF_ZERO)) |-> (outData == '0)); // R7

endmodule

bind fxc_convert fxc_convert_chk #(.OUT_W(OUT_W), .OUT_SIGNED(OUT_SIGNED)) uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .outValid(outValid),
  .outData(outData), .ovfFlag(ovfFlag), .stageMode(strobe.s2Mode)
);

// File: tb/tb_fxc_convert.sv
`timescale 1ns/1ps
module tb_fxc_convert;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic        roundMode = 1'b0;
  logic [1:0]  ovfMode = 2'd0;
  logic        outValid, ovfFlag, padValid, padOvf;
  logic [11:0] outData;
  logic [7:0]  padData;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  // main instance: Q16.13 signed -> Q12.9 signed
  fxc_convert dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .roundMode(roundMode), .ovfMode(ovfMode),
    .outValid(outValid), .outData(outData), .ovfFlag(ovfFlag)
  );

  // second instance: Q16.13 signed -> 8-bit unsigned with 15 fraction bits
  fxc_convert #(.OUT_W(8), .OUT_FRAC(15), .OUT_SIGNED(1'b0)) dutPad (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .roundMode(roundMode), .ovfMode(ovfMode),
    .outValid(padValid), .outData(padData), .ovfFlag(padOvf)
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input longint x, input int outW, input int outFrac,
                                input bit outSigned, input bit rnd, input int mode,
                                output longint res, output bit ovf);
    longint v, hi, lo;
    int sh;
    sh = 13 - outFrac;
    v = x;
    if (sh > 0) begin
      if (rnd) v = v + (longint'(1) <<< (sh - 1));
      v = v >>> sh;
    end else begin
      v = v <<< (-sh);
    end
    hi = outSigned ? (longint'(1) <<< (outW - 1)) - 1 : (longint'(1) <<< outW) - 1;
    lo = outSigned ? -(longint'(1) <<< (outW - 1)) : 0;
    ovf = (v > hi) || (v < lo);
    if (ovf && mode == 1) v = (v > hi) ? hi : lo;
    else if (ovf && mode == 2) v = 0;
    res = v & ((longint'(1) <<< outW) - 1);
  endfunction

  task automatic apply(longint x, bit rnd, int mode, string tag);
    longint eMain, ePad;
    bit oMain, oPad;
    model(x, 12, 9, 1'b1, rnd, mode, eMain, oMain);
    model(x, 8, 15, 1'b0, rnd, mode, ePad, oPad);
    @(negedge clk);
    inData = 16'(x); roundMode = rnd; ovfMode = 2'(mode); inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; roundMode = ~rnd; ovfMode = 2'd3;
    check({"R1 early ", tag}, outValid, 0);
    @(negedge clk);
    check({"R1 valid ", tag}, outValid, 1);
    check({tag, " data"}, outData, eMain);
    check({"R8 ", tag, " ovf"}, ovfFlag, oMain);
    check({"R9 R10 pad ", tag, " data"}, padData, ePad);
    check({"R8 R10 pad ", tag, " ovf"}, padOvf, oPad);
    @(negedge clk);
    check({"R1 pulse ", tag}, outValid, 0);
    check({"R8 pulse ", tag}, ovfFlag, 0);
    check({"R11 hold ", tag}, outData, eMain);
  endtask

  task automatic test_reset;
    check("R1 reset outValid", outValid, 0);
    check("R1 reset ovfFlag", ovfFlag, 0);
    check("R1 reset outData", outData, 0);
  endtask

  task automatic test_trunc;
    apply(16'sh1234, 1'b0, 0, "R2 trunc pos");
    apply(-24, 1'b0, 0, "R2 trunc neg");
    apply(-32768, 1'b0, 0, "R2 trunc min");
  endtask

  task automatic test_round;
    apply(24, 1'b1, 0, "R3 round half pos");
    apply(-24, 1'b1, 0, "R3 round half neg");
    apply(16'sh1234, 1'b1, 0, "R3 round below half");
  endtask

  task automatic test_carry_modes;
    apply(32767, 1'b0, 1, "R4 no carry fits");
    apply(32767, 1'b1, 0, "R4 R5 carry wrap");
    apply(32767, 1'b1, 3, "R5 spare code wraps");
    apply(32767, 1'b1, 1, "R6 carry saturate");
    apply(32767, 1'b1, 2, "R7 carry zero");
  endtask

  task automatic test_pad_unsigned;
    apply(10, 1'b1, 1, "R9 pad fits");
    apply(-5, 1'b0, 1, "R10 negative saturate");
    apply(-5, 1'b0, 0, "R10 negative wrap");
    apply(100, 1'b0, 2, "R7 R10 pad over zero");
  endtask

  task automatic test_back_to_back;
    @(negedge clk);
    inData = 16'sd48; roundMode = 1'b0; ovfMode = 2'd0; inValid = 1'b1;
    @(negedge clk);
    inData = 16'sd32767; roundMode = 1'b1; ovfMode = 2'd1;
    @(negedge clk);
    inValid = 1'b0;
    check("R1 b2b first valid", outValid, 1);
    check("R1 b2b first data", outData, 3);
    check("R8 b2b first ovf", ovfFlag, 0);
    @(negedge clk);
    check("R1 b2b second valid", outValid, 1);
    check("R6 b2b second data", outData, 2047);
    check("R8 b2b second ovf", ovfFlag, 1);
    @(negedge clk);
    check("R1 b2b drained", outValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    test_reset();
    test_trunc();
    test_round();
    test_carry_modes();
    test_pad_unsigned();
    test_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule